// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores one enable bit for each crosspoint of an 8 by 8 switch matrix. Three row address bits and three column address bits select one of the 64 bits. A single data bit and a strobe write it. The 64 bits leave the block as a parallel bus that drives the switch enables directly. Any pattern of enables is allowed, so several rows may connect to one column, and one row may connect to several columns.

The write port follows latch semantics, but the block is built from clocked logic. The strobe, the data bit and the address all pass through a two-flop synchronizer. While the synchronized strobe is high, the selected bit follows the data bit. When the strobe is seen to fall, the data bit sampled on that clock is written to the address that the strobe window held, and the bit then stays frozen. A separate active-high clear input drives every bit to zero without waiting for a clock edge. The clear overrides any write in progress.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While rst_ni is low, every bit of xp_en_o is 0.
- R2: The row and column select bit xp_en_o[col_i*8 + row_i]. For example, row 1 / column 0 is bit 1 and row 0 / column 1 is bit 8.
- R3: Writing data 1 sets the addressed bit to 1 (crosspoint on). Writing data 0 sets it to 0 (crosspoint off).
- R4: While strobe_i is high, the addressed bit follows data_i, including changes made during the strobe window.
- R5: After strobe_i falls, the addressed bit keeps the value data_i had when the fall was sampled. Later changes to data_i have no effect.
- R6: A write changes only the addressed bit. The other 63 bits keep their values.
- R7: Raising clr_i clears all 64 bits immediately, without a clock edge, and they stay 0 while clr_i is high.
- R8: While clr_i is high, a strobe with data 1 sets no bit. A strobe that ends before clr_i falls leaves all bits at 0.
- R9: Any combination of bits may be 1 at the same time, up to all 64.
- R10: A change on strobe_i or data_i, driven between clock edges, reaches xp_en_o on the third rising clock edge after it and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clr_i | input | 1 | Asynchronous active-high clear of all crosspoints |
| strobe_i | input | 1 | Asynchronous write strobe, active high |
| data_i | input | 1 | Value to write to the addressed crosspoint |
| row_i | input | 3 | Row select (X) |
| col_i | input | 3 | Column select (Y) |
| xp_en_o | output | 64 | Crosspoint enables, bit index col*8+row |

## Verification
The bench writes every one of the 64 crosspoints on and then off, comparing the whole bus after each write. This catches a swapped row/column index or a write that disturbs a neighbouring bit. Each strobe window toggles data mid-window and then changes data after the fall. A design that writes only on the edge, or that keeps following data after the fall, fails these checks. Clear is raised between clock edges and sampled before the next edge to expose a synchronous clear. It is also held over a strobe with data 1 to expose a write that leaks through the clear. The first write is sampled after two and after three edges to pin down the synchronizer depth.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_ROW_W = 3;
  localparam int unsigned XPT_COL_W = 3;
  localparam int unsigned XPT_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_OPEN  = 2'd1,
    WR_CLOSE = 2'd2
  } wr_op_e;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
  parameter int unsigned AW = 6,
  localparam int unsigned N = 1 << AW
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel_o[i] = en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
  import xpt_pkg::*;
#(
  parameter int unsigned ROW_W  = XPT_ROW_W,
  parameter int unsigned COL_W  = XPT_COL_W,
  parameter int unsigned STAGES = XPT_SYNC_STAGES,
  localparam int unsigned AW = ROW_W + COL_W,
  localparam int unsigned N  = 1 << AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic             data_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [N-1:0]     xp_en_o
);
  localparam int unsigned SW = AW + 2;

  logic [SW-1:0] sync_d, sync_q;
  logic          stb_s, data_s;
  logic [AW-1:0] addr_s;

  // column is the high part of the linear index
  assign sync_d = {strobe_i, data_i, col_i, row_i};

  xpt_sync #(.WIDTH(SW), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {stb_s, data_s, addr_s} = sync_q;

  logic          stb_q;
  logic [AW-1:0] addr_hold_q;
  wr_op_e        wr_op;
  logic [AW-1:0] wr_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q       <= 1'b0;
      addr_hold_q <= '0;
    end else begin
      stb_q <= stb_s;
      if (stb_s) addr_hold_q <= addr_s;
    end
  end

  always_comb begin
    if (stb_s)      wr_op = WR_OPEN;
    else if (stb_q) wr_op = WR_CLOSE;
    else            wr_op = WR_IDLE;
  end

  // closing write reuses the address held during the window
  assign wr_addr = (wr_op == WR_OPEN) ? addr_s : addr_hold_q;

  logic [N-1:0] sel;

  xpt_decode #(.AW(AW)) u_dec (
    .en_i  (wr_op != WR_IDLE),
    .addr_i(wr_addr),
    .sel_o (sel)
  );

  logic [N-1:0] bits_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
      if (!rst_ni)     bits_q[i] <= 1'b0;
      else if (clr_i)  bits_q[i] <= 1'b0;
      else if (sel[i]) bits_q[i] <= data_s;
    end
  end

  assign xp_en_o = bits_q;

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (xp_en_o == '0));

  // R4
  follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (wr_op != WR_IDLE) |=> (xp_en_o[$past(wr_addr)] == $past(data_s)));

  // R6
  single_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $onehot0(xp_en_o & ~$past(xp_en_o)));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (wr_op == WR_IDLE) |=> (xp_en_o == $past(xp_en_o)));
endmodule

// File: tb/xpt_ctrl_mem_test.sv
module xpt_ctrl_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        stb = 1'b0;
  logic        dat = 1'b0;
  logic [2:0]  row = '0;
  logic [2:0]  col = '0;
  logic [63:0] xp;
  logic [63:0] exp_v = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  xpt_ctrl_mem uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .clr_i   (clr),
    .strobe_i(stb),
    .data_i  (dat),
    .row_i   (row),
    .col_i   (col),
    .xp_en_o (xp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, ex);
    end
  endtask

  // linear index computed arithmetically: col*8+row
  task automatic write(input int idx, input bit val);
    row = 3'(idx % 8);
    col = 3'(idx / 8);
    dat = val;
    tick(1);
    stb = 1'b1;
    tick(4);
    check(xp[col*8+row] == val, "R3", 64'(xp[idx]), 64'(val));
    dat = ~val;
    tick(4);
    check(xp[idx] == ~val, "R4", 64'(xp[idx]), 64'(~val));
    dat = val;
    tick(4);
    stb = 1'b0;
    tick(4);
    dat = ~val;
    tick(4);
    exp_v[idx] = val;
    check(xp == exp_v, "R5 R6 R2", xp, exp_v);
  endtask

  initial begin
    tick(3);
    check(xp == '0, "R1", xp, '0);
    rst_n = 1'b1;
    tick(2);

    // R10: third edge, not second
    row = 3'd1; col = 3'd0; dat = 1'b1; stb = 1'b1;
    tick(2);
    check(xp == '0, "R10 early", xp, '0);
    tick(1);
    check(xp == 64'h2, "R10 R2 row1", xp, 64'h2);
    stb = 1'b0;
    tick(4);
    exp_v = 64'h2;
    write(1, 1'b0);
    write(8, 1'b1);
    check(xp == 64'h100, "R2 col1", xp, 64'h100);
    write(8, 1'b0);

    for (int i = 0; i < 64; i++) write(i, 1'b1);
    check(xp == '1, "R9 all on", xp, '1);
    for (int i = 63; i >= 0; i -= 2) write(i, 1'b0);
    check(xp == {32{2'b01}}, "R9 pattern", xp, {32{2'b01}});

    // R7: async clear seen before any edge
    @(posedge clk); #2;
    clr = 1'b1;
    #1;
    check(xp == '0, "R7 async", xp, '0);
    exp_v = '0;
    tick(3);
    check(xp == '0, "R7 hold", xp, '0);

    // R8: strobe with data 1 under clear
    row = 3'd5; col = 3'd6; dat = 1'b1; stb = 1'b1;
    tick(6);
    check(xp == '0, "R8 during", xp, '0);
    stb = 1'b0;
    tick(5);
    clr = 1'b0;
    tick(5);
    check(xp == '0, "R8 after", xp, '0);

    write(53, 1'b1);
    write(0, 1'b1);
    check(xp == exp_v, "R6 final", xp, exp_v);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", xp, exp_v);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule